// File: doc/BRIEF.md
# Programmable Single-Channel DMA Engine

This block is one general-purpose DMA channel. Software loads a source address, a destination address, a byte count and a control word through a small register port. The channel then copies data over a single-beat memory bus. Each unit of data is one read beat from the source followed by one write beat to the destination. The transfer runs at full speed in memory-to-memory mode. In the other modes it is paced by one of three request lines: an external request or either of two serial-port requests.

The control word sets the pacing source and the transfer width. It also sets increment, decrement or hold addressing, chosen separately for source and destination. Further bits select single, four-beat burst, block, demand and continuous sequencing, and enable the completion interrupt. In a serial-port mode a direction bit holds the address on the serial-port side constant.

When the count runs out, the channel either returns to idle or reloads its starting values and runs again. If the interrupt is enabled, it gives a one-cycle interrupt pulse.

Top module: `dma_chan`

## Requirements
- R1: After reset, all four registers read zero, `irq_o` and `mem_req_o` are low, and no memory beat is issued. The register addresses are:
  - 0: current source address.
  - 1: current destination address.
  - 2: remaining byte count.
  - 3: control word, where bit 1 reads the busy flag.
- R2: Control bit 0 (run) is stored as 1 only when both of these hold: the width field [13:12] is not 11, and the channel is busy or the count is non-zero. Otherwise run reads 0 and no memory beat is issued.
- R3: Width code 00 is a byte, 01 a halfword and 10 a word; `mem_size_o` carries this code. Each unit lowers the count by the width in bytes, and the count goes to 0 when fewer bytes remain. Data passes through unchanged from the read beat to the write beat.
- R4: For the source address, bit 5 makes it decrement and bit 7 holds it fixed. For the destination address, bit 4 makes it decrement and bit 6 holds it fixed. A fix bit overrides the matching direction bit. A moving address steps by the width in bytes once per unit.
- R5: Pacing code 00 in bits [3:2] copies the whole count without waiting for any request.
- R6: At the end of a non-continuous transfer, run and busy clear. If bit 8 is set, `irq_o` pulses high for exactly one cycle. If bit 8 is clear, no pulse is given.
- R7: With bit 11 clear (single mode), each rising edge of the selected request moves one unit. If bit 9 is also set, each edge moves four units. A request held high moves nothing further.
- R8: With bit 11 set (block mode), one rising edge of the selected request moves the whole count.
- R9: With bit 15 set (demand mode), a unit starts only while the selected request is high. The request is sampled before each unit.
- R10: The pacing code selects the request line: 01 selects `dreq_i`, 10 selects `uart0_req_i` and 11 selects `uart1_req_i`. The two lines not selected have no effect.
- R11: In pacing modes 10 and 11, the address on the serial-port side is held constant whatever the fix bits say. With bit 10 = 1 (memory to serial port) this is the destination address. With bit 10 = 0 (serial port to memory) it is the source address.
- R12: With bit 14 set (continuous mode), reaching a count of zero does the following: the channel reloads the starting addresses and count, stays busy, and pulses the interrupt on each pass if bit 8 is set.
- R13: Clearing run stops the channel before the next unit starts. A unit already in progress finishes both of its beats, busy then falls and no further beats are issued. Writes to registers 0 to 2 while busy are ignored.
- R14: Once `mem_req_o` is high, it stays high with a stable address and direction until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Register write address |
| reg_wdata_i | input | RW | Register write data |
| reg_raddr_i | input | 2 | Register read address |
| reg_rdata_o | output | RW | Register read data (combinational) |
| dreq_i | input | 1 | External transfer request |
| uart0_req_i | input | 1 | Serial port 0 request |
| uart1_req_i | input | 1 | Serial port 1 request |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | AW | Beat byte address |
| mem_size_o | output | 2 | Beat width code |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with ack |
| mem_ack_i | input | 1 | Beat completion |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The assertions rely on three assumptions about the memory side:
- it acknowledges each beat at most once;
- it gives no acknowledge while no request is pending;
- it returns read data in the same cycle as the acknowledge.

The bench memory model meets these by raising `mem_ack_i` for exactly one cycle, one cycle after each new request. The assertions also assume that software does not change the width or pacing fields while a unit is in flight. The bench writes the control word only when the channel is idle, or to clear run. Request lines change only on falling clock edges and are held long enough for one full unit to finish.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {PACE_SW = 2'd0, PACE_DREQ = 2'd1, PACE_U0 = 2'd2, PACE_U1 = 2'd3} pace_e;
  typedef enum logic [1:0] {AM_INC = 2'd0, AM_DEC = 2'd1, AM_FIX = 2'd2} amode_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_RD = 2'd2, ST_WR = 2'd3} state_e;

  // bit positions form the software interface
  typedef struct packed {
    logic       demand;   // 15
    logic       cont;     // 14
    logic [1:0] tw;       // 13:12
    logic       block;    // 11
    logic       to_port;  // 10
    logic       burst;    // 9
    logic       irq_en;   // 8
    logic       src_fix;  // 7
    logic       dst_fix;  // 6
    logic       src_dec;  // 5
    logic       dst_dec;  // 4
    pace_e      pace;     // 3:2
    logic       busy;     // 1
    logic       run;      // 0
  } ctrl_t;

  localparam logic [1:0] TW_BAD = 2'b11;

  function automatic logic [2:0] width_bytes(input logic [1:0] tw);
    case (tw)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          reload_i,
  input  logic          step_i,
  input  amode_e        mode_i,
  input  logic [2:0]    step_bytes_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] start_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      cur_q   <= '0;
    end else if (load_i) begin
      start_q <= load_val_i;
      cur_q   <= load_val_i;
    end else if (reload_i) begin
      cur_q <= start_q;
    end else if (step_i) begin
      case (mode_i)
        AM_INC:  cur_q <= cur_q + AW'(step_bytes_i);
        AM_DEC:  cur_q <= cur_q - AW'(step_bytes_i);
        default: cur_q <= cur_q;
      endcase
    end
  end

  assign addr_o = cur_q;

  // R4: a held address does not move on a step
  p_fix_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && mode_i == AM_FIX && !load_i && !reload_i |=> $stable(addr_o));
endmodule

// File: rtl/dma_pacer.sv
module dma_pacer
  import dma_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  pace_e pace_i,
  input  logic  dreq_i,
  input  logic  uart0_req_i,
  input  logic  uart1_req_i,
  input  logic  consume_i,
  input  logic  clr_i,
  output logic  level_o,
  output logic  pend_o
);
  logic lvl_q, pend_q, rise;

  always_comb begin
    case (pace_i)
      PACE_DREQ: level_o = dreq_i;
      PACE_U0:   level_o = uart0_req_i;
      PACE_U1:   level_o = uart1_req_i;
      default:   level_o = 1'b0;
    endcase
  end

  assign rise = level_o & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= level_o;
      pend_q <= clr_i ? 1'b0 : (rise | (pend_q & ~consume_i));
    end
  end

  assign pend_o = pend_q;

  // R7: a grant is only raised by the selected line
  p_pend_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(level_o));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int CW        = 16,
  parameter int DW        = 32,
  parameter int BURST_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          pace_sw_i,
  input  logic          demand_i,
  input  logic          block_i,
  input  logic          burst_i,
  input  logic          cont_i,
  input  logic          irq_en_i,
  input  logic [1:0]    tw_i,
  input  logic          level_i,
  input  logic          pend_i,
  input  logic          cnt_load_i,
  input  logic [CW-1:0] cnt_val_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] wdata_o,
  output logic          consume_o,
  output logic          step_o,
  output logic          reload_o,
  output logic          done_o,
  output logic          irq_o,
  output logic [CW-1:0] cnt_o
);
  localparam int BW = $clog2(BURST_LEN + 1);

  state_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_start_q;
  logic [BW-1:0] burst_q;
  logic          blk_q, irq_q;
  logic [DW-1:0] data_q;
  logic [2:0]    wb;
  logic          go, last, beat_done;

  assign wb        = width_bytes(tw_i);
  assign last      = cnt_q <= CW'(wb);
  assign beat_done = (state_q == ST_WR) && mem_ack_i;
  assign go        = pace_sw_i | (demand_i ? level_i : (pend_i | (block_i & blk_q)));
  assign consume_o = (state_q == ST_WAIT) && run_i && go;
  assign step_o    = beat_done;
  assign reload_o  = beat_done && last && cont_i;
  assign done_o    = beat_done && last && !cont_i;
  assign busy_o    = state_q != ST_IDLE;
  assign mem_req_o = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o  = state_q == ST_WR;
  assign wdata_o   = data_q;
  assign irq_o     = irq_q;
  assign cnt_o     = cnt_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (run_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!run_i) state_d = ST_IDLE;
        else if (go) state_d = ST_RD;
      end
      ST_RD: if (mem_ack_i) state_d = ST_WR;
      ST_WR: begin
        if (mem_ack_i) begin
          if (last) state_d = cont_i ? ST_WAIT : ST_IDLE;
          else if (burst_q != '0 && run_i) state_d = ST_RD;
          else state_d = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      cnt_start_q <= '0;
      burst_q     <= '0;
      blk_q       <= 1'b0;
      irq_q       <= 1'b0;
      data_q      <= '0;
    end else begin
      state_q <= state_d;
      irq_q   <= beat_done && last && irq_en_i;
      if (cnt_load_i) begin
        cnt_q       <= cnt_val_i;
        cnt_start_q <= cnt_val_i;
      end else if (reload_o) begin
        cnt_q <= cnt_start_q;
      end else if (beat_done) begin
        cnt_q <= last ? '0 : cnt_q - CW'(wb);
      end
      if (consume_o) burst_q <= burst_i ? BW'(BURST_LEN - 1) : '0;
      else if (beat_done && burst_q != '0) burst_q <= burst_q - BW'(1);
      if (!busy_o || (beat_done && last)) blk_q <= 1'b0;
      else if (consume_o && block_i) blk_q <= 1'b1;
      if (state_q == ST_RD && mem_ack_i) data_q <= mem_rdata_i;
    end
  end

  // R3: the count never rises except on a load or a reload
  p_cnt_mono_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_load_i && !reload_o |=> cnt_o <= $past(cnt_o));
  // R6: interrupt follows a completed write beat
  p_irq_after_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_we_o && mem_ack_i && irq_en_i));
  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R9: demand mode never starts a unit with the request low
  p_demand_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT && run_i && demand_i && !pace_sw_i && !level_i |=> !mem_req_o);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int RW        = 32,
  parameter int CW        = 16,
  parameter int BURST_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_waddr_i,
  input  logic [RW-1:0] reg_wdata_i,
  input  logic [1:0]    reg_raddr_i,
  output logic [RW-1:0] reg_rdata_o,
  input  logic          dreq_i,
  input  logic          uart0_req_i,
  input  logic          uart1_req_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          irq_o
);
  localparam int NADDR = 2;  // 0 source, 1 destination

  ctrl_t         ctrl_q, ctrl_rd;
  logic          busy, done, reload, step, consume, level, pend;
  logic [CW-1:0] cnt;
  logic          wr_ctrl, wr_cnt, port_mode, bad_tw;
  logic [AW-1:0] addr_w [NADDR];
  logic          load_w [NADDR];
  amode_e        mode_w [NADDR];
  logic          fix_w  [NADDR];
  logic          dec_w  [NADDR];

  assign wr_ctrl   = reg_we_i && reg_waddr_i == 2'd3;
  assign wr_cnt    = reg_we_i && reg_waddr_i == 2'd2 && !busy;
  assign load_w[0] = reg_we_i && reg_waddr_i == 2'd0 && !busy;
  assign load_w[1] = reg_we_i && reg_waddr_i == 2'd1 && !busy;
  assign bad_tw    = reg_wdata_i[13:12] == TW_BAD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q      <= ctrl_t'(reg_wdata_i[15:0]);
      ctrl_q.busy <= 1'b0;
      ctrl_q.run  <= reg_wdata_i[0] && !bad_tw && (busy || cnt != '0);
    end else if (done) begin
      ctrl_q.run <= 1'b0;
    end
  end

  // serial-port side address is held regardless of the fix bits
  assign port_mode = ctrl_q.pace == PACE_U0 || ctrl_q.pace == PACE_U1;
  assign fix_w[0]  = ctrl_q.src_fix | (port_mode & ~ctrl_q.to_port);
  assign fix_w[1]  = ctrl_q.dst_fix | (port_mode & ctrl_q.to_port);
  assign dec_w[0]  = ctrl_q.src_dec;
  assign dec_w[1]  = ctrl_q.dst_dec;

  for (genvar i = 0; i < NADDR; i++) begin : g_addr
    assign mode_w[i] = fix_w[i] ? AM_FIX : (dec_w[i] ? AM_DEC : AM_INC);
    dma_addr_gen #(.AW(AW)) u_gen (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load_w[i]),
      .load_val_i  (reg_wdata_i[AW-1:0]),
      .reload_i    (reload),
      .step_i      (step),
      .mode_i      (mode_w[i]),
      .step_bytes_i(width_bytes(ctrl_q.tw)),
      .addr_o      (addr_w[i])
    );
  end

  dma_pacer u_pacer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pace_i     (ctrl_q.pace),
    .dreq_i     (dreq_i),
    .uart0_req_i(uart0_req_i),
    .uart1_req_i(uart1_req_i),
    .consume_i  (consume),
    .clr_i      (!busy),
    .level_o    (level),
    .pend_o     (pend)
  );

  dma_seq #(.CW(CW), .DW(DW), .BURST_LEN(BURST_LEN)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl_q.run),
    .pace_sw_i  (ctrl_q.pace == PACE_SW),
    .demand_i   (ctrl_q.demand),
    .block_i    (ctrl_q.block),
    .burst_i    (ctrl_q.burst),
    .cont_i     (ctrl_q.cont),
    .irq_en_i   (ctrl_q.irq_en),
    .tw_i       (ctrl_q.tw),
    .level_i    (level),
    .pend_i     (pend),
    .cnt_load_i (wr_cnt),
    .cnt_val_i  (reg_wdata_i[CW-1:0]),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .busy_o     (busy),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .wdata_o    (mem_wdata_o),
    .consume_o  (consume),
    .step_o     (step),
    .reload_o   (reload),
    .done_o     (done),
    .irq_o      (irq_o),
    .cnt_o      (cnt)
  );

  assign mem_addr_o = mem_we_o ? addr_w[1] : addr_w[0];
  assign mem_size_o = ctrl_q.tw;

  always_comb begin
    ctrl_rd      = ctrl_q;
    ctrl_rd.busy = busy;
    case (reg_raddr_i)
      2'd0:    reg_rdata_o = RW'(addr_w[0]);
      2'd1:    reg_rdata_o = RW'(addr_w[1]);
      2'd2:    reg_rdata_o = RW'(cnt);
      default: reg_rdata_o = RW'(ctrl_rd);
    endcase
  end

  // R14: a pending beat holds its request, address and direction
  p_req_hold_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R2: a channel only leaves idle when run was accepted with a count
  p_start_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(ctrl_q.run) && $past(cnt != '0));
  p_run_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.run |-> ctrl_q.tw != TW_BAD);
endmodule

// File: tb/dma_chan_tb.sv
`timescale 1ns/1ps
module dma_chan_tb;
  localparam real CLK_NS = 20.0;  // 50 MHz

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_waddr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [1:0]  reg_raddr_i = '0;
  logic [31:0] reg_rdata_o;
  logic        dreq_i = 1'b0, uart0_req_i = 1'b0, uart1_req_i = 1'b0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [1:0]  mem_size_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ack_i = 1'b0;
  logic        irq_o;

  int tests = 0, fails = 0;
  int irq_cnt = 0, req_cyc = 0, hold_viol = 0;
  logic init_go = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic [7:0] exp_s, exp_d;
  logic prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  dma_chan u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_waddr_i(reg_waddr_i),
    .reg_wdata_i(reg_wdata_i), .reg_raddr_i(reg_raddr_i), .reg_rdata_o(reg_rdata_o),
    .dreq_i(dreq_i), .uart0_req_i(uart0_req_i), .uart1_req_i(uart1_req_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_size_o(mem_size_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_ack_i(mem_ack_i), .irq_o(irq_o)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  // memory model: one-cycle ack, little-endian lanes
  always @(posedge clk_i) begin
    logic [31:0] rd;
    int nb;
    if (init_go) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end
    nb = (mem_size_o == 2'd0) ? 1 : (mem_size_o == 2'd1) ? 2 : 4;
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i <= 1'b1;
      if (mem_we_o) begin
        for (int k = 0; k < nb; k++) mem[mem_addr_o[7:0] + 8'(k)] <= mem_wdata_o[8*k +: 8];
      end else begin
        rd = '0;
        for (int k = 0; k < nb; k++) rd[8*k +: 8] = mem[mem_addr_o[7:0] + 8'(k)];
        mem_rdata_i <= rd;
      end
    end else begin
      mem_ack_i <= 1'b0;
    end
    if (prev_pend && (!mem_req_o || mem_addr_o != prev_addr)) hold_viol <= hold_viol + 1;
    prev_pend <= mem_req_o && !mem_ack_i;
    prev_addr <= mem_addr_o;
    if (irq_o) irq_cnt <= irq_cnt + 1;
    if (mem_req_o) req_cyc <= req_cyc + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_waddr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_raddr_i = a;
    #2;
    d = reg_rdata_o;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic mem_init();
    @(negedge clk_i); init_go = 1'b1;
    @(negedge clk_i); init_go = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    logic [31:0] v;
    for (int i = 0; i < lim; i++) begin
      rd(2'd3, v);
      if (!v[1]) break;
    end
  endtask

  task automatic pulse(input int which, input int len);
    @(negedge clk_i);
    if (which == 0) dreq_i = 1'b1; else if (which == 1) uart0_req_i = 1'b1; else uart1_req_i = 1'b1;
    repeat (len) @(negedge clk_i);
    dreq_i = 1'b0; uart0_req_i = 1'b0; uart1_req_i = 1'b0;
    idle_cycles(30);
  endtask

  task automatic model(input logic [15:0] c, input logic [7:0] s0, input logic [7:0] d0, input int cn);
    int wb, n;
    logic [7:0] s, d;
    logic [7:0] tmp [4];
    wb = (c[13:12] == 2'd0) ? 1 : (c[13:12] == 2'd1) ? 2 : 4;
    s = s0; d = d0; n = cn;
    for (int i = 0; i < 256; i++) expm[i] = pat(i);
    while (n > 0) begin
      for (int k = 0; k < wb; k++) tmp[k] = expm[s + 8'(k)];
      for (int k = 0; k < wb; k++) expm[d + 8'(k)] = tmp[k];
      if (!c[7]) s = c[5] ? s - 8'(wb) : s + 8'(wb);
      if (!c[6]) d = c[4] ? d - 8'(wb) : d + 8'(wb);
      n = (n > wb) ? n - wb : 0;
    end
    exp_s = s; exp_d = d;
  endtask

  function automatic int mem_mismatch();
    int m = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) m++;
    return m;
  endfunction

  task automatic setup(input logic [7:0] s, input logic [7:0] d, input logic [15:0] n);
    wr(2'd0, {24'h0, s});
    wr(2'd1, {24'h0, d});
    wr(2'd2, {16'h0, n});
  endtask

  // {ctrl[15:0], src[7:0], dst[7:0], count[7:0]}
  localparam logic [39:0] VEC [9] = '{
    40'h0101_00_80_08,  // byte, both increment
    40'h1101_10_90_08,  // halfword
    40'h2101_20_A0_10,  // word
    40'h0121_3F_B0_06,  // source decrements
    40'h2181_40_C0_0C,  // source fixed
    40'h0141_48_D0_04,  // destination fixed
    40'h2301_50_E0_10,  // four-beat bursts
    40'h1101_60_F0_05,  // odd count, halfword
    40'h2111_70_FC_0C   // destination decrements
  };

  initial begin
    #(CLK_NS * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2;
    int base, rq;
    idle_cycles(3);
    rst_ni = 1'b1;
    idle_cycles(2);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), v, 32'h0);
    end
    chk("R1 irq and request low", {30'h0, irq_o, mem_req_o}, 32'h0);

    // vector walk: memory-to-memory transfers (R3 R4 R5 R6)
    for (int i = 0; i < 9; i++) begin
      logic [39:0] e;
      e = VEC[i];
      mem_init();
      model(e[39:24], e[23:16], e[15:8], int'(e[7:0]));
      base = irq_cnt;
      setup(e[23:16], e[15:8], {8'h0, e[7:0]});
      wr(2'd3, {16'h0, e[39:24]});
      wait_idle(2000);
      idle_cycles(2);
      chk($sformatf("R5 R3 vec %0d memory image", i), mem_mismatch(), 0);
      rd(2'd0, v); chk($sformatf("R4 vec %0d final source", i), v, {24'h0, exp_s});
      rd(2'd1, v); chk($sformatf("R4 vec %0d final destination", i), v, {24'h0, exp_d});
      rd(2'd2, v); chk($sformatf("R3 vec %0d count drained", i), v, 32'h0);
      rd(2'd3, v); chk($sformatf("R6 vec %0d run and busy clear", i), {30'h0, v[1:0]}, 32'h0);
      chk($sformatf("R6 vec %0d one interrupt", i), irq_cnt - base, 1);
    end

    // R2 bad width and zero count do not start
    mem_init();
    setup(8'h00, 8'h80, 16'd4);
    rq = req_cyc;
    wr(2'd3, 32'h3101);
    rd(2'd3, v); chk("R2 width 11 leaves run clear", {30'h0, v[1:0]}, 32'h0);
    idle_cycles(20);
    chk("R2 width 11 issues no beat", req_cyc - rq, 0);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0101);
    rd(2'd3, v); chk("R2 zero count leaves run clear", {30'h0, v[1:0]}, 32'h0);
    idle_cycles(20);
    chk("R2 zero count issues no beat", req_cyc - rq, 0);

    // R6 interrupt disabled
    mem_init();
    base = irq_cnt;
    setup(8'h00, 8'h80, 16'd2);
    wr(2'd3, 32'h0001);
    wait_idle(500);
    idle_cycles(5);
    chk("R6 no interrupt when bit 8 clear", irq_cnt - base, 0);
    chk("R5 copy without interrupt", {mem[8'h81], mem[8'h80]}, {16'h0, pat(1), pat(0)});

    // R7 single mode on external request; R13 register writes ignored while busy
    mem_init();
    base = irq_cnt;
    setup(8'h00, 8'h80, 16'd3);
    wr(2'd3, 32'h0105);
    @(negedge clk_i); dreq_i = 1'b1;
    idle_cycles(40);
    rd(2'd2, v); chk("R7 one unit per rising edge", v, 32'd2);
    idle_cycles(40);
    rd(2'd2, v); chk("R7 held request moves nothing more", v, 32'd2);
    dreq_i = 1'b0;
    idle_cycles(5);
    pulse(0, 3);
    rd(2'd2, v); chk("R7 second edge moves one unit", v, 32'd1);
    wr(2'd0, 32'h33);
    rd(2'd0, v); chk("R13 source write ignored while busy", v, 32'h02);
    pulse(0, 3);
    wait_idle(200);
    rd(2'd2, v); chk("R7 third edge drains count", v, 32'd0);
    chk("R7 single bytes copied", {8'h0, mem[8'h82], mem[8'h81], mem[8'h80]},
        {8'h0, pat(2), pat(1), pat(0)});
    chk("R6 single mode interrupt", irq_cnt - base, 1);

    // R7 single mode with four-beat bursts
    mem_init();
    setup(8'h00, 8'h80, 16'd8);
    wr(2'd3, 32'h0305);
    pulse(0, 3);
    idle_cycles(40);
    rd(2'd2, v); chk("R7 burst edge moves four units", v, 32'd4);
    pulse(0, 3);
    wait_idle(200);
    rd(2'd2, v); chk("R7 second burst drains count", v, 32'd0);

    // R8 block mode
    mem_init();
    model(16'h0905, 8'h00, 8'h80, 6);
    setup(8'h00, 8'h80, 16'd6);
    wr(2'd3, 32'h0905);
    pulse(0, 2);
    idle_cycles(80);
    rd(2'd3, v); chk("R8 block edge completes transfer", {30'h0, v[1:0]}, 32'h0);
    chk("R8 block memory image", mem_mismatch(), 0);

    // R9 demand mode
    mem_init();
    setup(8'h00, 8'h80, 16'd40);
    wr(2'd3, 32'h8105);
    @(negedge clk_i); dreq_i = 1'b1;
    idle_cycles(30);
    dreq_i = 1'b0;
    idle_cycles(12);
    rd(2'd2, c1);
    chk("R9 moved while request high", (c1 > 0 && c1 < 40) ? 32'd1 : 32'd0, 32'd1);
    idle_cycles(50);
    rd(2'd2, c2);
    chk("R9 no movement while request low", c2, c1);
    @(negedge clk_i); dreq_i = 1'b1;
    wait_idle(1000);
    dreq_i = 1'b0;
    rd(2'd2, v); chk("R9 drains once request returns", v, 32'd0);

    // R10 R11 port pacing, memory to port 1
    mem_init();
    setup(8'h10, 8'h90, 16'd2);
    wr(2'd3, 32'h050D);
    pulse(0, 3);
    pulse(1, 3);
    rd(2'd2, v); chk("R10 unselected lines ignored", v, 32'd2);
    pulse(2, 3);
    rd(2'd2, v); chk("R10 selected port line moves a unit", v, 32'd1);
    pulse(2, 3);
    wait_idle(200);
    rd(2'd1, v); chk("R11 destination held toward port", v, 32'h90);
    rd(2'd0, v); chk("R11 source advances", v, 32'h12);
    chk("R11 last byte lands at port address", {24'h0, mem[8'h90]}, {24'h0, pat(8'h11)});

    // R11 port 0 to memory
    mem_init();
    setup(8'h20, 8'hA0, 16'd2);
    wr(2'd3, 32'h0109);
    pulse(1, 3);
    pulse(1, 3);
    wait_idle(200);
    rd(2'd0, v); chk("R11 source held toward port", v, 32'h20);
    rd(2'd1, v); chk("R11 destination advances", v, 32'hA2);

    // R12 continuous, then R13 stop
    mem_init();
    base = irq_cnt;
    setup(8'h00, 8'h80, 16'd4);
    wr(2'd3, 32'h4101);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (irq_cnt - base >= 2) break;
    end
    chk("R12 interrupt on each pass", (irq_cnt - base >= 2) ? 32'd1 : 32'd0, 32'd1);
    rd(2'd3, v); chk("R12 still running after reload", {30'h0, v[1:0]}, 32'h3);
    wr(2'd3, 32'h0);
    idle_cycles(20);
    rd(2'd3, v); chk("R13 busy falls after stop", {30'h0, v[1:0]}, 32'h0);
    rq = req_cyc;
    idle_cycles(20);
    chk("R13 no beat after stop", req_cyc - rq, 0);

    chk("R14 request held until ack", hold_viol, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule